// File: doc/BRIEF.md
# Port LED Status Field Formatter

This block builds the per-port status field that a serial LED chain controller inserts into its shift stream. For each of up to eight ports it holds a six-bit software status value and two hardware activity inputs, one for transmit and one for receive. A four-bit layout code chooses how many status bits appear and whether activity is shown as one combined bit, as separate transmit and receive bits, or not at all.

The chain controller asks for one field bit at a time by giving a port number and a bit position. One clock later the block returns that bit and the field length for the current layout. Short activity bursts are stretched: each port and direction keeps a hold flag. The flag is released only at a blink-period boundary that had no activity since the previous boundary. The blink period is a programmable number of the controller's latch strobes.

Top module: `port_led_field`

## Requirements
- R1: Layout codes 0x0, 0x1, 0x2 and 0x3 give only status bits, with field lengths 1, 2, 4 and 6. Field position p carries status[p].
- R2: Layout codes 0x4, 0x5 and 0x6 give lengths 2, 3 and 5. Position 0 carries the OR of the transmit and receive hold flags. Position p ≥ 1 carries status[p-1].
- R3: Layout codes 0x8, 0x9 and 0xA give lengths 3, 4 and 6. Position 0 carries the transmit hold flag, position 1 the receive hold flag, and position p ≥ 2 status[p-2].
- R4: Layout codes 0x7 and 0xB to 0xF behave exactly like code 0x0.
- R5: A requested position at or beyond the field length returns 0.
- R6: An activity input that is high for one cycle sets that port's hold flag at the same clock edge. The flag is visible in a request made in the following cycle.
- R7: A hold flag clears only at a blink boundary that saw no activity in that direction since the previous boundary. A burst therefore stays visible for at least one full blink period.
- R8: A blink boundary occurs on the latch strobe that completes rate strobes since the previous boundary. A rate of 0 acts as 1, so every strobe is a boundary.
- R9: bit_o and len_o reflect the port, position, layout code, status and hold flags present in the cycle before the clock edge that updates them.
- R10: While rst_ni is low, bit_o and len_o are 0, all hold flags are clear and the blink count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 4 | Field layout code |
| blink_rate_i | input | 8 | Blink period in latch strobes |
| latch_i | input | 1 | Latch strobe from the chain controller |
| sw_status_i | input | 48 | Software status, six bits per port, port 0 in the low bits |
| tx_act_i | input | 8 | Transmit activity per port |
| rx_act_i | input | 8 | Receive activity per port |
| sel_port_i | input | 3 | Requested port |
| sel_bit_i | input | 3 | Requested field position |
| bit_o | output | 1 | Requested field bit |
| len_o | output | 3 | Field length of the current layout |

## Verification
Field bit and length are due one edge after a request. The hold flags change at the same edge as the activity or boundary that moves them, so a flag change shows in a request made one cycle later. The blink count moves only on latch strobes. A behavioural model in the bench follows these rules. At each rising edge it computes the expected outputs from the inputs and the flags held before that edge, then updates its own flags and count. The outputs are compared at the next falling edge, so every check samples the one-cycle result exactly when it is due. New stimulus is applied after each comparison.

// File: rtl/port_led_pkg.sv
package port_led_pkg;
  localparam int STAT_W  = 6;
  localparam int FPOS_W  = 3;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ANY   = 2'd1,
    ACT_SPLIT = 2'd2
  } act_mode_e;

  typedef struct packed {
    act_mode_e         mode;
    logic [FPOS_W-1:0] nstat;
  } layout_t;

  function automatic layout_t decode_layout(input logic [3:0] code);
    layout_t l;
    unique case (code)
      4'h1:    l = '{ACT_NONE,  3'd2};
      4'h2:    l = '{ACT_NONE,  3'd4};
      4'h3:    l = '{ACT_NONE,  3'd6};
      4'h4:    l = '{ACT_ANY,   3'd1};
      4'h5:    l = '{ACT_ANY,   3'd2};
      4'h6:    l = '{ACT_ANY,   3'd4};
      4'h8:    l = '{ACT_SPLIT, 3'd1};
      4'h9:    l = '{ACT_SPLIT, 3'd2};
      4'hA:    l = '{ACT_SPLIT, 3'd4};
      default: l = '{ACT_NONE,  3'd1};
    endcase
    return l;
  endfunction
endpackage

// File: rtl/blink_timer.sv
module blink_timer #(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              period_edge_o
);
  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] eff_rate;
  logic              at_last;

  assign eff_rate      = (rate_i == '0) ? RATE_W'(1) : rate_i;
  assign at_last       = (cnt_q >= eff_rate - RATE_W'(1));
  assign period_edge_o = latch_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (period_edge_o) cnt_q <= '0;
    else if (latch_i)       cnt_q <= cnt_q + RATE_W'(1);
  end

  assert_cnt_still_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(cnt_q));
  assert_cnt_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_edge_o |=> (cnt_q == '0));
endmodule

// File: rtl/act_stretch.sv
module act_stretch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic period_edge_i,
  output logic hold_o
);
  logic seen_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (period_edge_i) begin
      hold_q <= seen_q | act_i;
      seen_q <= act_i;
    end else begin
      hold_q <= hold_q | act_i;
      seen_q <= seen_q | act_i;
    end
  end

  assign hold_o = hold_q;

  assert_hold_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_q) |-> $past(act_i));
  assert_hold_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> ($past(period_edge_i) && !$past(act_i)));
endmodule

// File: rtl/field_pick.sv
module field_pick
  import port_led_pkg::*;
(
  input  logic [3:0]        fmt_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              tx_hold_i,
  input  logic              rx_hold_i,
  input  logic [FPOS_W-1:0] pos_i,
  output logic              bit_o,
  output logic [FPOS_W-1:0] len_o
);
  layout_t           lay;
  logic [FPOS_W-1:0] offs;
  logic [FPOS_W-1:0] sidx;
  logic [7:0]        stat_pad;

  assign lay      = decode_layout(fmt_i);
  assign stat_pad = {{(8-STAT_W){1'b0}}, status_i};

  always_comb begin
    unique case (lay.mode)
      ACT_ANY:   offs = FPOS_W'(1);
      ACT_SPLIT: offs = FPOS_W'(2);
      default:   offs = '0;
    endcase
    len_o = lay.nstat + offs;
    sidx  = pos_i - offs;
    bit_o = 1'b0;
    if (pos_i < len_o) begin
      if (pos_i >= offs)          bit_o = stat_pad[sidx];
      else if (lay.mode == ACT_ANY) bit_o = tx_hold_i | rx_hold_i;
      else if (pos_i == '0)       bit_o = tx_hold_i;
      else                        bit_o = rx_hold_i;
    end
  end
endmodule

// File: rtl/port_led_field.sv
module port_led_field
  import port_led_pkg::*;
#(
  parameter int NPORT  = 8,
  parameter int RATE_W = 8,
  localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [3:0]              fmt_i,
  input  logic [RATE_W-1:0]       blink_rate_i,
  input  logic                    latch_i,
  input  logic [NPORT*STAT_W-1:0] sw_status_i,
  input  logic [NPORT-1:0]        tx_act_i,
  input  logic [NPORT-1:0]        rx_act_i,
  input  logic [PORT_W-1:0]       sel_port_i,
  input  logic [FPOS_W-1:0]       sel_bit_i,
  output logic                    bit_o,
  output logic [FPOS_W-1:0]       len_o
);
  logic              period_edge;
  logic [NPORT-1:0]  tx_hold, rx_hold;
  logic [STAT_W-1:0] sel_status;
  logic              pick_bit;
  logic [FPOS_W-1:0] pick_len;

  blink_timer #(.RATE_W(RATE_W)) u_timer (
    .clk_i, .rst_ni, .latch_i, .rate_i(blink_rate_i), .period_edge_o(period_edge)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    act_stretch u_tx (.clk_i, .rst_ni, .act_i(tx_act_i[g]),
                      .period_edge_i(period_edge), .hold_o(tx_hold[g]));
    act_stretch u_rx (.clk_i, .rst_ni, .act_i(rx_act_i[g]),
                      .period_edge_i(period_edge), .hold_o(rx_hold[g]));
  end

  assign sel_status = sw_status_i[sel_port_i*STAT_W +: STAT_W];

  field_pick u_pick (
    .fmt_i, .status_i(sel_status),
    .tx_hold_i(tx_hold[sel_port_i]), .rx_hold_i(rx_hold[sel_port_i]),
    .pos_i(sel_bit_i), .bit_o(pick_bit), .len_o(pick_len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o <= 1'b0;
      len_o <= '0;
    end else begin
      bit_o <= pick_bit;
      len_o <= pick_len;
    end
  end

  assert_pad_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> ($past(sel_bit_i) < len_o));
  assert_len_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_o <= FPOS_W'(6));
  assert_len_nonzero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (len_o != '0));
endmodule

// File: tb/port_led_field_test.sv
module port_led_field_test;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  fmt = '0;
  logic [7:0]  rate = 8'd1;
  logic        latch = 1'b0;
  logic [47:0] status = '0;
  logic [7:0]  tx = '0, rx = '0;
  logic [2:0]  sport = '0, sbit = '0;
  logic        bit_o;
  logic [2:0]  len_o;

  always #2 clk = ~clk;

  port_led_field uut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .blink_rate_i(rate), .latch_i(latch),
    .sw_status_i(status), .tx_act_i(tx), .rx_act_i(rx),
    .sel_port_i(sport), .sel_bit_i(sbit), .bit_o(bit_o), .len_o(len_o)
  );

  int total = 0, bad = 0;
  string phase = "";

  // behavioural reference
  int  mcnt;
  bit  htx[NP], hrx[NP], stx[NP], srx[NP];
  int  e_bit, e_len;
  string e_tag;

  function automatic int ref_mode(input int f);
    if (f >= 4 && f <= 6) return 1;
    if (f >= 8 && f <= 10) return 2;
    return 0;
  endfunction

  function automatic int ref_nstat(input int f);
    case (f)
      1, 5, 9:  return 2;
      2, 6, 10: return 4;
      3:        return 6;
      default:  return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt = 0; e_bit = 0; e_len = 0; e_tag = "R10";
      for (int i = 0; i < NP; i++) begin htx[i] = 0; hrx[i] = 0; stx[i] = 0; srx[i] = 0; end
    end else begin
      int p, b, f, m, ln, eff;
      bit bnd;
      p = sport; b = sbit; f = fmt;
      m = ref_mode(f); ln = ref_nstat(f) + m;
      e_len = ln;
      if (b >= ln) e_bit = 0;
      else if (b >= m) e_bit = status[p*6 + b - m];
      else if (m == 1) e_bit = htx[p] | hrx[p];
      else if (b == 0) e_bit = htx[p];
      else e_bit = hrx[p];
      if (phase != "") e_tag = phase;
      else if (b >= ln) e_tag = "R5";
      else if (f <= 3) e_tag = "R1";
      else if (m == 1) e_tag = "R2";
      else if (m == 2) e_tag = "R3";
      else e_tag = "R4";
      eff = (rate == 0) ? 1 : rate;
      bnd = latch && (mcnt >= eff - 1);
      if (latch) mcnt = bnd ? 0 : mcnt + 1;
      for (int i = 0; i < NP; i++) begin
        if (bnd) begin
          htx[i] = stx[i] | tx[i]; stx[i] = tx[i];
          hrx[i] = srx[i] | rx[i]; srx[i] = rx[i];
        end else begin
          htx[i] = htx[i] | tx[i]; stx[i] = stx[i] | tx[i];
          hrx[i] = hrx[i] | rx[i]; srx[i] = srx[i] | rx[i];
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    total++;
    if (bit_o !== e_bit[0] || len_o !== e_len[2:0]) begin
      bad++;
      $display("FAIL %s: bit_o=%0d len_o=%0d expected bit=%0d len=%0d",
               e_tag, bit_o, len_o, e_bit, e_len);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    int k;
    // R10: reset state
    repeat (3) @(negedge clk);
    total++;
    if (bit_o !== 1'b0 || len_o !== 3'd0) begin
      bad++;
      $display("FAIL R10: bit_o=%0d len_o=%0d expected 0 0", bit_o, len_o);
    end
    rst_n = 1'b1;
    tick();

    // R1..R5: sweep every code, port and position
    rate = 8'd2; k = 0;
    for (int f = 0; f < 16; f++)
      for (int p = 0; p < NP; p++)
        for (int b = 0; b < 8; b++) begin
          fmt = f[3:0]; sport = p[2:0]; sbit = b[2:0];
          status = {$urandom, $urandom};
          tx = 8'($urandom); rx = 8'($urandom);
          latch = (k % 3 == 0); k++;
          tick();
        end

    // R6: single-cycle pulse seen one cycle later
    phase = "R6"; tx = '0; rx = '0; latch = 1'b0; rate = 8'd4;
    repeat (20) begin latch = 1'b1; tick(); end
    latch = 1'b0; fmt = 4'h8; sport = 3'd3; sbit = 3'd0;
    tick();
    tx[3] = 1'b1; tick();
    tx[3] = 1'b0;
    repeat (4) tick();
    sbit = 3'd1; rx[3] = 1'b1; tick();
    rx[3] = 1'b0; repeat (4) tick();

    // R7: stretch across blink periods
    phase = "R7"; rate = 8'd3; fmt = 4'h4; sport = 3'd5; sbit = 3'd0;
    for (int c = 0; c < 40; c++) begin
      latch = (c % 2 == 0);
      rx[5] = (c == 5) || (c == 22);
      tick();
    end
    rx = '0;

    // R8: rate zero acts as one
    phase = "R8"; rate = 8'd0; fmt = 4'h9; sport = 3'd1;
    for (int c = 0; c < 60; c++) begin
      latch = ($urandom % 2) == 0;
      tx[1] = ($urandom % 7) == 0; rx[1] = ($urandom % 9) == 0;
      sbit = 3'($urandom % 2);
      tick();
    end
    rate = 8'd1;
    for (int c = 0; c < 30; c++) begin
      latch = ($urandom % 2) == 0; tx[1] = (c == 3); sbit = 3'd0; tick();
    end

    // R9: everything changes every cycle
    phase = "R9";
    for (int c = 0; c < 300; c++) begin
      fmt = 4'($urandom); sport = 3'($urandom); sbit = 3'($urandom);
      status = {$urandom, $urandom}; rate = 8'($urandom % 5);
      latch = ($urandom % 3) == 0;
      tx = 8'($urandom) & 8'($urandom); rx = 8'($urandom) & 8'($urandom);
      tick();
    end

    // mixed random traffic, requirement tags by field class
    phase = "";
    for (int c = 0; c < 4000; c++) begin
      fmt = 4'($urandom); sport = 3'($urandom); sbit = 3'($urandom);
      if ($urandom % 16 == 0) status = {$urandom, $urandom};
      if ($urandom % 64 == 0) rate = 8'($urandom % 6);
      latch = ($urandom % 4) == 0;
      tx = 8'($urandom) & 8'($urandom) & 8'($urandom);
      rx = 8'($urandom) & 8'($urandom) & 8'($urandom);
      tick();
    end
    summary();
  end
endmodule